// File: doc/BRIEF.md
# Nibble ALU with Registered Zero and Carry Flags

This block is the arithmetic and logic unit of a 4-bit accumulator processor. It combines the accumulator value with a second operand under a 2-bit function code. The four functions are add with carry-in, NOR, compare, and a pass-through of the operand. The result and carry-out are combinational. A zero indication is formed by an OR tree over the result bits, so every function can drive it, not only compare.

Two flag registers, Zero and Carry, capture the combinational indications on a clock edge when the flag-load strobe is high. Zero is refreshed by every function, so a load, an input or a NOR can be followed at once by a jump on zero. Carry is refreshed only by add and compare. Conditional jumps elsewhere in the processor test both flags.

The block also reports whether the function writes the accumulator. Compare does not write it. The accumulator register and the instruction decoder sit outside this block.

Top module: `nib_alu`

## Requirements
- R1: With function code 00 (add), the result is the low 4 bits of a + b + carry_in, and carry_out is bit 4 of that sum.
- R2: With function code 01 (NOR), the result is the bitwise NOR of a and b, and carry_out is 0.
- R3: With function code 10 (compare), the result is the low 4 bits of a + ~b + 1, and carry_out is 1 exactly when a >= b as unsigned values. The carry input has no effect.
- R4: With function code 11 (pass), the result equals b, and carry_out is 0.
- R5: acc_wr is 1 for function codes 00, 01 and 11, and 0 for 10.
- R6: zero_out is 1 exactly when all four result bits are 0, for every function code.
- R7: On a rising clock edge with flag_ld high, zero_flag takes the value of zero_out, for every function code.
- R8: On a rising clock edge with flag_ld high, carry_flag takes carry_out for function codes 00 and 10, and keeps its value for 01 and 11.
- R9: On a rising clock edge with flag_ld low, both flags keep their values.
- R10: While rst_n is low, both flags are 0 at once. After rst_n rises, the first two rising edges load nothing, and the third edge is the first that can load the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 4 | Accumulator operand |
| b | input | 4 | Second operand (memory, immediate or input value) |
| carry_in | input | 1 | Carry input for add |
| func | input | 2 | Function code: 00 add, 01 NOR, 10 compare, 11 pass |
| flag_ld | input | 1 | Flag-load strobe for the next clock edge |
| result | output | 4 | Combinational result |
| carry_out | output | 1 | Combinational carry-out |
| zero_out | output | 1 | Combinational zero indication |
| acc_wr | output | 1 | The function writes the accumulator |
| zero_flag | output | 1 | Registered Zero flag |
| carry_flag | output | 1 | Registered Carry flag |

## Verification
The assertions check on every cycle the relation between the zero indication and the result, that compare never asks for an accumulator write, and how the flags load or hold under the strobe and function code. Only the bench's scenarios can show the arithmetic itself. The bench sweeps every operand pair, carry input and function code and checks each result and carry against a computed value. It also checks the asynchronous clearing of the flags and the two dead edges after reset is released.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_NOR  = 2'b01,
    FN_CMP  = 2'b10,
    FN_PASS = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/nib_rst_sync.sv
module nib_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         co,
  output logic         wr,
  output logic         cy_upd
);
  logic [W:0] sum;

  always_comb begin
    sum    = '0;
    res    = '0;
    co     = 1'b0;
    wr     = 1'b1;
    cy_upd = 1'b0;
    case (fn)
      FN_ADD: begin
        sum    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        res    = sum[W-1:0];
        co     = sum[W];
        cy_upd = 1'b1;
      end
      FN_NOR: begin
        res = ~(a | b);
      end
      FN_CMP: begin
        sum    = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        res    = sum[W-1:0];
        co     = sum[W];
        wr     = 1'b0;
        cy_upd = 1'b1;
      end
      default: begin
        res = b;
      end
    endcase
  end
endmodule

// File: rtl/nib_zero_tree.sv
module nib_zero_tree #(
  parameter int W = 4
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  localparam int LVLS = (W > 1) ? $clog2(W) : 0;
  localparam int P    = 1 << LVLS;
  localparam int N    = 2 * P - 1;

  logic [N-1:0] node;

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < W) begin : g_bit
      assign node[P-1+i] = val[i];
    end else begin : g_pad
      assign node[P-1+i] = 1'b0;
    end
  end

  for (genvar k = 0; k < P - 1; k++) begin : g_or
    assign node[k] = node[2*k+1] | node[2*k+2];
  end

  assign is_zero = ~node[0];
endmodule

// File: rtl/nib_flag_reg.sv
module nib_flag_reg (
  input  logic clk,
  input  logic srst_n,
  input  logic ld,
  input  logic cy_upd,
  input  logic z_in,
  input  logic c_in,
  output logic z_q,
  output logic c_q
);
  logic z_d;
  logic c_d;

  always_comb begin
    z_d = z_q;
    c_d = c_q;
    if (ld) begin
      z_d = z_in;
      if (cy_upd) c_d = c_in;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      z_q <= z_d;
      c_q <= c_d;
    end
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W          = 4,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_in,
  input  logic [1:0]   func,
  input  logic         flag_ld,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero_out,
  output logic         acc_wr,
  output logic         zero_flag,
  output logic         carry_flag
);
  alu_fn_e fn;
  logic    srst_n;
  logic    cy_upd;

  assign fn = alu_fn_e'(func);

  nib_rst_sync #(.STAGES(RST_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  nib_alu_core #(.W(W)) u_core (
    .a      (a),
    .b      (b),
    .cin    (carry_in),
    .fn     (fn),
    .res    (result),
    .co     (carry_out),
    .wr     (acc_wr),
    .cy_upd (cy_upd)
  );

  nib_zero_tree #(.W(W)) u_zero (
    .val     (result),
    .is_zero (zero_out)
  );

  nib_flag_reg u_flags (
    .clk    (clk),
    .srst_n (srst_n),
    .ld     (flag_ld),
    .cy_upd (cy_upd),
    .z_in   (zero_out),
    .c_in   (carry_out),
    .z_q    (zero_flag),
    .c_q    (carry_flag)
  );
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         srst_n,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         zero_out,
  input logic         acc_wr,
  input logic [1:0]   func,
  input logic         flag_ld,
  input logic         zero_flag,
  input logic         carry_flag
);
  p_zero_tracks_result_r6: assert property (@(posedge clk) disable iff (!srst_n)
    zero_out == (result == '0));

  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (func == 2'b10) |-> !acc_wr);

  p_zero_load_r7: assert property (@(posedge clk) disable iff (!srst_n)
    flag_ld |=> (zero_flag == $past(zero_out)));

  p_carry_load_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (flag_ld && !func[0]) |=> (carry_flag == $past(carry_out)));

  p_carry_keep_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (flag_ld && func[0]) |=> $stable(carry_flag));

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !flag_ld |=> ($stable(zero_flag) && $stable(carry_flag)));
endmodule

bind nib_alu nib_alu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .result     (result),
  .carry_out  (carry_out),
  .zero_out   (zero_out),
  .acc_wr     (acc_wr),
  .func       (func),
  .flag_ld    (flag_ld),
  .zero_flag  (zero_flag),
  .carry_flag (carry_flag)
);

// File: tb/nib_alu_test.sv
`timescale 1ns/1ps
module nib_alu_test;
  logic       clk;
  logic       rst_n;
  logic [3:0] a;
  logic [3:0] b;
  logic       carry_in;
  logic [1:0] func;
  logic       flag_ld;
  logic [3:0] result;
  logic       carry_out;
  logic       zero_out;
  logic       acc_wr;
  logic       zero_flag;
  logic       carry_flag;

  int n_chk;
  int n_fail;
  bit done;
  int ez;
  int ec;

  nib_alu uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .a          (a),
    .b          (b),
    .carry_in   (carry_in),
    .func       (func),
    .flag_ld    (flag_ld),
    .result     (result),
    .carry_out  (carry_out),
    .zero_out   (zero_out),
    .acc_wr     (acc_wr),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (func=%0d a=%0d b=%0d cin=%0d)",
               tag, act, exp, func, a, b, carry_in);
    end
  endtask

  task automatic check_flags(input string tag);
    chk({tag, " zero_flag"}, int'(zero_flag), ez);
    chk({tag, " carry_flag"}, int'(carry_flag), ec);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    ez = 0; ec = 0;
    rst_n = 1'b0; a = '0; b = '0; carry_in = 1'b0; func = 2'b00; flag_ld = 1'b0;
    repeat (3) @(negedge clk);
    check_flags("R10 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Exhaustive sweep of function, operands and carry input (R1..R9)
    for (int f = 0; f < 4; f++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          for (int ic = 0; ic < 2; ic++) begin
            int er;
            int eco;
            int ld;
            @(negedge clk);
            check_flags("R7/R8/R9 flags");
            ld = (((ia + ib + ic + f) % 3) != 0) ? 1 : 0;
            func = 2'(f); a = 4'(ia); b = 4'(ib); carry_in = ic[0]; flag_ld = ld[0];
            #1;
            case (f)
              0: begin er = (ia + ib + ic) % 16; eco = (ia + ib + ic) / 16; end
              1: begin er = (~(ia | ib)) & 15; eco = 0; end
              2: begin er = (ia - ib + 16) % 16; eco = (ia >= ib) ? 1 : 0; end
              default: begin er = ib; eco = 0; end
            endcase
            case (f)
              0: begin chk("R1 add result", int'(result), er); chk("R1 add carry", int'(carry_out), eco); end
              1: begin chk("R2 nor result", int'(result), er); chk("R2 nor carry", int'(carry_out), eco); end
              2: begin chk("R3 cmp result", int'(result), er); chk("R3 cmp carry", int'(carry_out), eco); end
              default: begin chk("R4 pass result", int'(result), er); chk("R4 pass carry", int'(carry_out), eco); end
            endcase
            chk("R5 acc_wr", int'(acc_wr), (f == 2) ? 0 : 1);
            chk("R6 zero_out", int'(zero_out), (er == 0) ? 1 : 0);
            if (ld != 0) begin
              ez = (er == 0) ? 1 : 0;
              if (f == 0 || f == 2) ec = eco;
            end
          end
        end
      end
    end
    @(negedge clk);
    check_flags("R7/R8/R9 final");

    // Load both flags to 1, then check async clear and two dead edges (R10)
    func = 2'b00; a = 4'd15; b = 4'd1; carry_in = 1'b0; flag_ld = 1'b1;
    @(negedge clk);
    ez = 1; ec = 1;
    check_flags("R8 setup");
    #3 rst_n = 1'b0;
    #1;
    ez = 0; ec = 0;
    check_flags("R10 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    func = 2'b00; a = 4'd15; b = 4'd1; flag_ld = 1'b1;
    @(negedge clk);
    check_flags("R10 dead edge 1");
    @(negedge clk);
    check_flags("R10 dead edge 2");
    @(negedge clk);
    ez = 1; ec = 1;
    check_flags("R10 first load");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule